// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of a packet-driven disk DMA engine with several channels. A host reaches it over a plain memory-mapped bus with 16-bit data, per-byte write enables and single-cycle read strobes. Each channel owns a window of registers. The window holds a control word, a status word and a packet count. It also holds a 32-bit next-packet pointer, a 32-bit lookup word and two FIFO threshold words. The control word carries four fields: an interrupt mask, a start trigger, an engine reset and a transfer-mode field.

A global unlock byte sits outside the channel windows. The start trigger only launches the packet fetcher after the key value has been written to that byte. A launch produces a one-cycle start pulse towards the fetcher and marks the channel busy. The engine reports completion or failure through event inputs. Each event latches a status flag and ends the busy state. The flags are cleared by reading the status word. The channel interrupt is the OR of its flags, gated by the mask. Holding the engine-reset bit keeps the channel idle and its flags empty.

Top module: `dmactl_csr`

## Requirements
- R1: After the synchronous reset, control reads 0x0100 (mask set, mode 0), status reads 0, the unlock byte reads 0, and every irq, busy and start_pulse output is 0.
- R2: When the channel is unlocked, a write to control with byte lane 0 enabled launches the channel if it meets two conditions: bit 7 is 1 and bit 5 is 0, and the engine-reset bit held before the write is 0. The launch drives start_pulse for exactly the following cycle. Bit 7 always reads back as 0.
- R3: The unlock byte is the upper byte of the word at 0xC6 (byte address 0xC7). The start trigger is honoured only while it holds 0x07. With any other value the trigger is ignored: there is no pulse and busy stays unchanged.
- R4: Status bit 6 (packet error), bit 4 (unexpected interrupt) and bit 0 (parity error) latch on their event inputs. A status read returns the flags and clears them. An event that arrives in the same cycle as the read is kept for the next read.
- R5: irq of a channel is 1 exactly when any status flag is set and control bit 8 (mask) is 0.
- R6: While control bit 5 (engine reset) is 1, status stays 0, busy is 0, events are not recorded and start requests are ignored.
- R7: The next-packet pointer is written as two halves: the low half at offset 0x0C and the high half at 0x0E. Bits 2:0 always read 0 and are driven as 0 on pkt_ptr.
- R8: For every writable word, only the byte lanes whose enable is set are updated (bus_be bit 0 covers data bits 7:0, bit 1 covers bits 15:8).
- R9: Channel n's window starts at 0x80 + n*0x20. Writes and launches in one window leave every other channel unchanged.
- R10: busy is set by a launch and cleared by any status event or by the engine-reset bit. A launch takes priority over an event in the same cycle.
- R11: bus_rdata is registered. It shows the addressed word in the cycle after bus_rd, and 0 when bus_rd was low or the address maps to no register.
- R12: xfer_mode follows control bits 1:0 of each channel. Value 3 selects the fastest programmed-I/O mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, bit 0 ignored for word access |
| bus_be | input | 2 | Byte-lane write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_pkt_err | input | NCH | Per-channel packet error event |
| ev_unexp | input | NCH | Per-channel unexpected interrupt event |
| ev_parity | input | NCH | Per-channel parity error event |
| start_pulse | output | NCH | One-cycle launch to the packet fetcher |
| irq | output | NCH | Masked channel interrupt |
| busy | output | NCH | Channel has a packet in flight |
| xfer_mode | output | 2*NCH | Transfer-mode field per channel |
| pkt_ptr | output | 32*NCH | Next-packet pointer per channel |
| pkt_count | output | 16*NCH | Packet count per channel |
| fifo_in_thr | output | 16*NCH | Input FIFO threshold per channel |
| fifo_out_thr | output | 16*NCH | Output FIFO threshold per channel |

## Verification
The embedded assertions check several rules on every clock. A start pulse must follow an unlocked cycle and must coincide with busy. A held engine reset must leave the flags, busy and the pulse empty. A status read with no colliding event must empty the flags. At most one channel window can decode at a time. Other behaviours depend on chosen sequences, so only the bench's scenarios can show them. These cover byte-lane merging, isolation between channels, an event that collides with a status read, the masking of a pending interrupt, and relocking through the unlock byte. A per-clock reference model backs these scenarios.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned CH_STRIDE = 32;
    localparam int unsigned WORD_W    = $clog2(CH_STRIDE) - 1;

    // word offsets (byte offset / 2) inside one channel window
    typedef enum logic [WORD_W-1:0] {
        W_CTRL  = 4'h0,
        W_STAT  = 4'h1,
        W_COUNT = 4'h2,
        W_PTRL  = 4'h6,
        W_PTRH  = 4'h7,
        W_LUTL  = 4'h8,
        W_LUTH  = 4'h9,
        W_FIN   = 4'hA,
        W_FOUT  = 4'hB
    } word_e;

    localparam int unsigned CTL_MASK = 8;
    localparam int unsigned CTL_GO   = 7;
    localparam int unsigned CTL_ERST = 5;

    localparam logic [7:0] UNLOCK_KEY  = 8'h07;
    localparam logic [7:0] UNLOCK_WORD = 8'hC6;

    typedef struct packed {
        logic       mask;
        logic       eng_rst;
        logic [1:0] mode;
    } ctrl_t;

    typedef struct packed {
        logic pkt_err;
        logic unexp;
        logic parity;
    } flags_t;

    function automatic logic [DATA_W-1:0] lane_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [1:0]        be
    );
        return {be[1] ? new_v[15:8] : old_v[15:8],
                be[0] ? new_v[7:0]  : old_v[7:0]};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_MASK] = c.mask;
        w[CTL_ERST] = c.eng_rst;
        w[1:0]      = c.mode;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] flags_word(input flags_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[6] = f.pkt_err;
        w[4] = f.unexp;
        w[0] = f.parity;
        return w;
    endfunction

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
    import dmactl_pkg::*;
#(
    parameter int unsigned NCH     = 2,
    parameter int unsigned CH_BASE = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    chan_hit,
    output logic [WORD_W-1:0] word,
    output logic              unlock_hit
);
    logic [31:0] a32;
    logic        unused_lsb;

    assign a32        = 32'(addr);
    assign unused_lsb = addr[0];
    assign word       = addr[WORD_W:1];
    assign unlock_hit = (addr[ADDR_W-1:1] == UNLOCK_WORD[ADDR_W-1:1]);

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        localparam int unsigned LO = CH_BASE + i * CH_STRIDE;
        localparam int unsigned HI = LO + CH_STRIDE;
        assign chan_hit[i] = (a32 >= 32'(LO)) && (a32 < 32'(HI));
    end

endmodule

// File: rtl/dmactl_channel.sv
module dmactl_channel
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              unlock,
    input  flags_t            ev,
    output logic [DATA_W-1:0] rdata,
    output logic              start_pulse,
    output logic              irq,
    output logic              busy,
    output logic [1:0]        mode,
    output logic [31:0]       ptr,
    output logic [15:0]       count,
    output logic [15:0]       fin,
    output logic [15:0]       fout
);
    ctrl_t             ctrl;
    flags_t            flags;
    logic [15:0]       lut_lo, lut_hi;
    logic              ctrl_wr, go_req, stat_clr, any_ev;
    logic [DATA_W-1:0] ptr_lo_new;

    assign ctrl_wr  = wr && (word == W_CTRL);
    assign go_req   = ctrl_wr && be[0] && wdata[CTL_GO] && !wdata[CTL_ERST]
                      && !ctrl.eng_rst && unlock;
    assign stat_clr = rd && (word == W_STAT);
    assign any_ev   = |ev;
    assign ptr_lo_new = lane_merge(ptr[15:0], wdata, be) & 16'hFFF8;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl        <= '{mask: 1'b1, eng_rst: 1'b0, mode: 2'd0};
            flags       <= '0;
            busy        <= 1'b0;
            start_pulse <= 1'b0;
            ptr         <= '0;
            count       <= '0;
            fin         <= '0;
            fout        <= '0;
            lut_lo      <= '0;
            lut_hi      <= '0;
        end else begin
            if (ctrl_wr) begin
                if (be[1]) ctrl.mask <= wdata[CTL_MASK];
                if (be[0]) begin
                    ctrl.eng_rst <= wdata[CTL_ERST];
                    ctrl.mode    <= wdata[1:0];
                end
            end
            start_pulse <= go_req;
            if (ctrl.eng_rst) begin
                flags <= '0;
                busy  <= 1'b0;
            end else begin
                flags <= (stat_clr ? flags_t'('0) : flags) | ev;
                if (go_req)      busy <= 1'b1;
                else if (any_ev) busy <= 1'b0;
            end
            if (wr) begin
                case (word)
                    W_COUNT: count      <= lane_merge(count, wdata, be);
                    W_PTRL:  ptr[15:0]  <= ptr_lo_new;
                    W_PTRH:  ptr[31:16] <= lane_merge(ptr[31:16], wdata, be);
                    W_LUTL:  lut_lo     <= lane_merge(lut_lo, wdata, be);
                    W_LUTH:  lut_hi     <= lane_merge(lut_hi, wdata, be);
                    W_FIN:   fin        <= lane_merge(fin, wdata, be);
                    W_FOUT:  fout       <= lane_merge(fout, wdata, be);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (word)
            W_CTRL:  rdata = ctrl_word(ctrl);
            W_STAT:  rdata = flags_word(flags);
            W_COUNT: rdata = count;
            W_PTRL:  rdata = ptr[15:0];
            W_PTRH:  rdata = ptr[31:16];
            W_LUTL:  rdata = lut_lo;
            W_LUTH:  rdata = lut_hi;
            W_FIN:   rdata = fin;
            W_FOUT:  rdata = fout;
            default: rdata = '0;
        endcase
    end

    assign irq  = (|flags) && !ctrl.mask;
    assign mode = ctrl.mode;

    // R3
    unlock_go_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> $past(unlock));

    // R10
    busy_on_go_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy);

    // R6
    erst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.eng_rst && !ctrl_wr) |=> (flags == '0 && !start_pulse && !busy));

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !any_ev) |=> (flags == '0));

endmodule

// File: rtl/dmactl_csr.sv
module dmactl_csr
    import dmactl_pkg::*;
#(
    parameter int unsigned NCH     = 2,
    parameter int unsigned CH_BASE = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_addr,
    input  logic [1:0]          bus_be,
    input  logic [15:0]         bus_wdata,
    output logic [15:0]         bus_rdata,
    input  logic [NCH-1:0]      ev_pkt_err,
    input  logic [NCH-1:0]      ev_unexp,
    input  logic [NCH-1:0]      ev_parity,
    output logic [NCH-1:0]      start_pulse,
    output logic [NCH-1:0]      irq,
    output logic [NCH-1:0]      busy,
    output logic [2*NCH-1:0]    xfer_mode,
    output logic [32*NCH-1:0]   pkt_ptr,
    output logic [16*NCH-1:0]   pkt_count,
    output logic [16*NCH-1:0]   fifo_in_thr,
    output logic [16*NCH-1:0]   fifo_out_thr
);
    logic [NCH-1:0]    chan_hit;
    logic [WORD_W-1:0] word;
    logic              unlock_hit;
    logic [7:0]        unlock_byte;
    logic              unlocked;
    logic [15:0]       ch_rdata [NCH];
    logic [15:0]       rd_mux;

    dmactl_decode #(.NCH(NCH), .CH_BASE(CH_BASE)) u_decode (
        .addr       (bus_addr),
        .chan_hit   (chan_hit),
        .word       (word),
        .unlock_hit (unlock_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            unlock_byte <= '0;
        else if (bus_wr && unlock_hit && bus_be[1])
            unlock_byte <= bus_wdata[15:8];
    end
    assign unlocked = (unlock_byte == UNLOCK_KEY);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dmactl_channel u_ch (
            .clk         (clk),
            .rst         (rst),
            .wr          (bus_wr && chan_hit[i]),
            .rd          (bus_rd && chan_hit[i]),
            .word        (word),
            .be          (bus_be),
            .wdata       (bus_wdata),
            .unlock      (unlocked),
            .ev          ('{pkt_err: ev_pkt_err[i], unexp: ev_unexp[i], parity: ev_parity[i]}),
            .rdata       (ch_rdata[i]),
            .start_pulse (start_pulse[i]),
            .irq         (irq[i]),
            .busy        (busy[i]),
            .mode        (xfer_mode[2*i +: 2]),
            .ptr         (pkt_ptr[32*i +: 32]),
            .count       (pkt_count[16*i +: 16]),
            .fin         (fifo_in_thr[16*i +: 16]),
            .fout        (fifo_out_thr[16*i +: 16])
        );
    end

    always_comb begin
        rd_mux = unlock_hit ? {unlock_byte, 8'h00} : 16'h0000;
        for (int i = 0; i < NCH; i++)
            if (chan_hit[i]) rd_mux = rd_mux | ch_rdata[i];
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= bus_rd ? rd_mux : 16'h0000;
    end

    // R9
    decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_hit));

endmodule

// File: tb/dmactl_csr_bench.sv
`timescale 1ns/100ps
module dmactl_csr_bench;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              bus_wr = 0, bus_rd = 0;
    logic [7:0]        bus_addr = 0;
    logic [1:0]        bus_be = 0;
    logic [15:0]       bus_wdata = 0;
    logic [15:0]       bus_rdata;
    logic [NCH-1:0]    ev_pkt_err = 0, ev_unexp = 0, ev_parity = 0;
    logic [NCH-1:0]    start_pulse, irq, busy;
    logic [2*NCH-1:0]  xfer_mode;
    logic [32*NCH-1:0] pkt_ptr;
    logic [16*NCH-1:0] pkt_count, fifo_in_thr, fifo_out_thr;

    dmactl_csr #(.NCH(NCH)) u_dmactl_csr (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ev_pkt_err(ev_pkt_err), .ev_unexp(ev_unexp),
        .ev_parity(ev_parity), .start_pulse(start_pulse), .irq(irq),
        .busy(busy), .xfer_mode(xfer_mode), .pkt_ptr(pkt_ptr),
        .pkt_count(pkt_count), .fifo_in_thr(fifo_in_thr),
        .fifo_out_thr(fifo_out_thr)
    );

    int errs = 0, checks = 0;
    bit done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_mask[NCH], m_erst[NCH], m_mode[NCH], m_flags[NCH];
    int          m_busy[NCH], m_go[NCH], m_cnt[NCH], m_fin[NCH], m_fout[NCH];
    int          m_lutl[NCH], m_luth[NCH];
    bit [31:0]   m_ptr[NCH];
    int          m_lock = 0, m_rdata = 0;

    function automatic int mrg(int old_v, int new_v, logic [1:0] be);
        return ((be[1] ? new_v : old_v) & 'hFF00) | ((be[0] ? new_v : old_v) & 'hFF);
    endfunction

    task automatic model_step();
        int a, v, base, w, evv, go, old_rst;
        bit hit;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_mask[c] = 1; m_erst[c] = 0; m_mode[c] = 0; m_flags[c] = 0;
                m_busy[c] = 0; m_go[c] = 0; m_cnt[c] = 0; m_fin[c] = 0;
                m_fout[c] = 0; m_lutl[c] = 0; m_luth[c] = 0; m_ptr[c] = 0;
            end
            m_lock = 0; m_rdata = 0;
            return;
        end
        a = int'(bus_addr);
        v = 0;
        if (bus_rd) begin
            if ((a >> 1) == ('hC6 >> 1)) v = m_lock << 8;
            for (int c = 0; c < NCH; c++) begin
                base = 128 + c * 32;
                if (a >= base && a < base + 32) begin
                    case ((a - base) >> 1)
                        0:  v = (m_mask[c] << 8) | (m_erst[c] << 5) | m_mode[c];
                        1:  v = m_flags[c];
                        2:  v = m_cnt[c];
                        6:  v = int'(m_ptr[c][15:0]);
                        7:  v = int'(m_ptr[c][31:16]);
                        8:  v = m_lutl[c];
                        9:  v = m_luth[c];
                        10: v = m_fin[c];
                        11: v = m_fout[c];
                        default: v = 0;
                    endcase
                end
            end
        end
        for (int c = 0; c < NCH; c++) begin
            base = 128 + c * 32;
            hit  = (a >= base && a < base + 32);
            w    = (a - base) >> 1;
            evv  = (ev_pkt_err[c] ? 64 : 0) | (ev_unexp[c] ? 16 : 0) | (ev_parity[c] ? 1 : 0);
            go   = 0;
            old_rst = m_erst[c];
            if (bus_wr && hit) begin
                case (w)
                    0: begin
                        if (bus_be[0] && bus_wdata[7] && !bus_wdata[5] && old_rst == 0 && m_lock == 7)
                            go = 1;
                        if (bus_be[1]) m_mask[c] = bus_wdata[8];
                        if (bus_be[0]) begin
                            m_erst[c] = bus_wdata[5];
                            m_mode[c] = bus_wdata[1:0];
                        end
                    end
                    2:  m_cnt[c]  = mrg(m_cnt[c], bus_wdata, bus_be);
                    6:  m_ptr[c][15:0]  = 16'(mrg(int'(m_ptr[c][15:0]), bus_wdata, bus_be) & 'hFFF8);
                    7:  m_ptr[c][31:16] = 16'(mrg(int'(m_ptr[c][31:16]), bus_wdata, bus_be));
                    8:  m_lutl[c] = mrg(m_lutl[c], bus_wdata, bus_be);
                    9:  m_luth[c] = mrg(m_luth[c], bus_wdata, bus_be);
                    10: m_fin[c]  = mrg(m_fin[c], bus_wdata, bus_be);
                    11: m_fout[c] = mrg(m_fout[c], bus_wdata, bus_be);
                    default: ;
                endcase
            end
            if (old_rst != 0) begin
                m_flags[c] = 0;
                m_busy[c]  = 0;
            end else begin
                if (bus_rd && hit && w == 1) m_flags[c] = 0;
                m_flags[c] = m_flags[c] | evv;
                if (go != 0)       m_busy[c] = 1;
                else if (evv != 0) m_busy[c] = 0;
            end
            m_go[c] = go;
        end
        if (bus_wr && (a >> 1) == ('hC6 >> 1) && bus_be[1]) m_lock = int'(bus_wdata[15:8]);
        m_rdata = v;
    endtask

    always @(posedge clk) begin
        model_step();
        #1;
        if (!done) begin
            for (int c = 0; c < NCH; c++) begin
                chk("R2 start_pulse vs model", start_pulse[c], m_go[c]);
                chk("R5 irq vs model", irq[c], (m_flags[c] != 0 && m_mask[c] == 0) ? 1 : 0);
                chk("R10 busy vs model", busy[c], m_busy[c]);
                chk("R12 xfer_mode vs model", xfer_mode[2*c +: 2], m_mode[c]);
                chk("R7 pkt_ptr vs model", pkt_ptr[32*c +: 32], m_ptr[c]);
                chk("R8 pkt_count vs model", pkt_count[16*c +: 16], m_cnt[c]);
                chk("R8 fifo_in_thr vs model", fifo_in_thr[16*c +: 16], m_fin[c]);
                chk("R8 fifo_out_thr vs model", fifo_out_thr[16*c +: 16], m_fout[c]);
            end
            chk("R11 bus_rdata vs model", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                       input logic [1:0] be, input logic [15:0] d,
                       input logic [NCH-1:0] ep = '0, input logic [NCH-1:0] eu = '0,
                       input logic [NCH-1:0] epar = '0);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_be = be; bus_wdata = d;
        ev_pkt_err = ep; ev_unexp = eu; ev_parity = epar;
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; bus_be = 0;
        ev_pkt_err = '0; ev_unexp = '0; ev_parity = '0;
    endtask

    task automatic wr16(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
        cyc(1'b1, 1'b0, a, be, d);
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [15:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 2'b00, 16'h0);
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        rd_exp(8'h80, 16'h0100, "R1 ctrl after reset");
        rd_exp(8'h82, 16'h0000, "R1 status after reset");
        rd_exp(8'hC6, 16'h0000, "R1 unlock byte after reset");
        chk("R1 irq/busy/start idle", {irq, busy, start_pulse}, 0);

        wr16(8'h80, 2'b11, 16'h0083);
        chk("R3 locked start ignored", start_pulse, 0);
        chk("R3 locked busy stays 0", busy, 0);
        chk("R12 mode 3 selected", xfer_mode[1:0], 3);

        wr16(8'hC6, 2'b10, 16'h0700);
        rd_exp(8'hC7, 16'h0700, "R3 unlock byte readback");

        wr16(8'h80, 2'b11, 16'h0083);
        chk("R2 launch pulse ch0", start_pulse, 2'b01);
        chk("R10 busy after launch", busy, 2'b01);
        cyc(1'b0, 1'b0, 8'h00, 2'b00, 16'h0);
        chk("R2 pulse lasts one cycle", start_pulse, 0);
        rd_exp(8'h80, 16'h0003, "R2 go bit reads 0");

        cyc(1'b0, 1'b0, 8'h00, 2'b00, 16'h0, 2'b00, 2'b00, 2'b01);
        chk("R5 irq on parity flag", irq, 2'b01);
        chk("R10 busy cleared by event", busy, 0);
        rd_exp(8'h82, 16'h0001, "R4 parity flag read");
        rd_exp(8'h82, 16'h0000, "R4 flags cleared by read");
        chk("R5 irq drops after clear", irq, 0);

        wr16(8'h80, 2'b10, 16'h0100);
        cyc(1'b0, 1'b0, 8'h00, 2'b00, 16'h0, 2'b00, 2'b01, 2'b00);
        chk("R5 masked irq stays 0", irq, 0);
        rd_exp(8'h82, 16'h0010, "R4 unexpected flag read");

        cyc(1'b0, 1'b1, 8'h82, 2'b00, 16'h0, 2'b01, 2'b00, 2'b00);
        chk("R4 colliding event not returned", bus_rdata, 0);
        rd_exp(8'h82, 16'h0040, "R4 colliding event kept");

        wr16(8'h80, 2'b01, 16'h0020);
        cyc(1'b0, 1'b0, 8'h00, 2'b00, 16'h0, 2'b01, 2'b01, 2'b01);
        rd_exp(8'h82, 16'h0000, "R6 events dropped in engine reset");
        wr16(8'h80, 2'b01, 16'h00A0);
        chk("R6 start ignored in engine reset", start_pulse, 0);
        chk("R6 busy 0 in engine reset", busy, 0);
        wr16(8'h80, 2'b01, 16'h0003);

        wr16(8'h8C, 2'b11, 16'hFFFF);
        rd_exp(8'h8C, 16'hFFF8, "R7 pointer low bits read 0");
        wr16(8'h8E, 2'b11, 16'h1234);
        chk("R7 pointer output", pkt_ptr[31:0], 32'h1234FFF8);

        wr16(8'h84, 2'b01, 16'hABCD);
        wr16(8'h84, 2'b10, 16'h1200);
        rd_exp(8'h84, 16'h12CD, "R8 byte lanes merged");

        wr16(8'hA4, 2'b11, 16'h5555);
        rd_exp(8'h84, 16'h12CD, "R9 ch0 untouched by ch1 write");
        rd_exp(8'hA4, 16'h5555, "R9 ch1 count");
        wr16(8'hA0, 2'b11, 16'h0083);
        chk("R9 launch only on ch1", start_pulse, 2'b10);

        rd_exp(8'h40, 16'h0000, "R11 unmapped address");
        rd_exp(8'h98, 16'h0000, "R11 unmapped window word");
        wr16(8'h94, 2'b11, 16'h0100);
        rd_exp(8'h94, 16'h0100, "R11 fifo threshold read");
        cyc(1'b0, 1'b0, 8'h94, 2'b00, 16'h0);
        chk("R11 rdata 0 without read", bus_rdata, 0);

        wr16(8'h80, 2'b01, 16'h0002);
        chk("R12 mode follows write", xfer_mode[1:0], 2);

        wr16(8'hC6, 2'b10, 16'h0300);
        wr16(8'h80, 2'b11, 16'h0080);
        chk("R3 relocked start ignored", start_pulse, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule